// File: doc/BRIEF.md
# Colour Lookup Table with In-Band Table Load

This block maps each pixel of an RGB stream through three 256-entry, 8-bit tables, one per colour component. A typical use is gamma correction. In indexed-colour mode the red lane carries a palette index that addresses all three tables at once and yields a full RGB triple. A bypass mode passes the pixel through untouched, with the same one-cycle latency as the lookup path. Switching modes between pixels therefore never shifts the stream.

The tables can be filled in two ways. A host port writes one entry per cycle. An in-band loader takes bytes from the red lane of the pixel stream inside a fixed line window. The window opens at pixel 0 of the line two lines before the programmed first active line. It closes at a programmable pixel position on the line just before the first active line. Loaded bytes are distributed red, green, blue, red, ... over rising entry numbers. The output is the mapped stream with a valid flag delayed to match the data.

A host write is dropped in any cycle that stores an in-band byte. A host select value of 3 writes nothing.

Top module: `clut_stage`

## Requirements
- R1: After reset, and before any valid pixel, `outValid` is 0 and `outR`, `outG`, `outB` are 0.
- R2: Outside bypass and indexed mode, a valid pixel (r,g,b) produces one cycle later `outValid`=1 and (redTable[r], greenTable[g], blueTable[b]); `outValid` is 0 one cycle after a cycle with `pixValid` low.
- R3: With `modeIndexed`=1 and `modeBypass`=0, the red lane value i produces one cycle later (redTable[i], greenTable[i], blueTable[i]); the green and blue lanes have no effect.
- R4: With `modeBypass`=1, the output one cycle later equals the input pixel. The mode is sampled per pixel, so alternating modes on consecutive pixels gives each pixel the output of its own mode.
- R5: A host write with `hostWe`=1 stores `hostData` at `hostAddr` in the table chosen by `hostSel` (0 red, 1 green, 2 blue). The entry can be read from the next cycle on.
- R6: While `modeInband`=1, every valid pixel inside the window supplies its red-lane value as load byte k (k counted from 0). Byte k goes to the table k mod 3 (0 red, 1 green, 2 blue), at entry k div 3.
- R7: The window covers every pixel of line `firstActive`-2. It also covers the pixels of line `firstActive`-1 whose `pixNum` is below `halfLine`. Bytes outside the window are not stored.
- R8: The byte count restarts at 0 at pixel 0 of line `firstActive`-2. Bytes after the 768th in one window are not stored.
- R9: When a host write and a pixel read hit the same entry in the same cycle, the output shows the value held before the write.
- R10: While `pixValid` is low, `outR`, `outG` and `outB` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | Input pixel qualifier |
| pixR | input | 8 | Red component, palette index, or in-band load byte |
| pixG | input | 8 | Green component |
| pixB | input | 8 | Blue component |
| lineNum | input | LINE_W | Current line number |
| pixNum | input | PIX_W | Pixel position within the line |
| firstActive | input | LINE_W | Programmed first active line |
| halfLine | input | PIX_W | Pixel position that closes the load window |
| modeBypass | input | 1 | Pass pixels through unchanged |
| modeIndexed | input | 1 | Red lane indexes all three tables |
| modeInband | input | 1 | Enable in-band table load |
| hostWe | input | 1 | Host write strobe |
| hostSel | input | 2 | Host table select |
| hostAddr | input | 8 | Host entry address |
| hostData | input | 8 | Host entry data |
| outValid | output | 1 | Output pixel qualifier |
| outR | output | 8 | Mapped red |
| outG | output | 8 | Mapped green |
| outB | output | 8 | Mapped blue |

## Verification
The assertions assume that `firstActive` is at least 2, so that the window lines do not wrap. They also assume that the mode bits and `pixR` are stable across each clock edge, so the bypass comparison against the previous input holds. The bench keeps `firstActive` at 10, drives every input at the falling edge and reads every output at the next falling edge. The in-band frames shorten `halfLine` in one frame so that the window closes before the 768th byte. They also put marker bytes after the window so that stray stores would show up in a later sweep of all entries.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int LUT_DW      = 8;
  localparam int LUT_ENTRIES = 1 << LUT_DW;
  localparam int NUM_LANES   = 3;
  localparam int CNT_W       = LUT_DW + 1;

  typedef logic [LUT_DW-1:0] lutByte_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_LANES-1:0] wrEn;
    lutByte_t             wrAddr;
    lutByte_t             wrData;
    logic                 useIndex;
    logic                 bypass;
  } lutStrobe_t;
endpackage

// File: rtl/clut_table.sv
module clut_table
  import clut_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  lutByte_t wrAddr,
  input  lutByte_t wrData,
  input  logic     rdEn,
  input  lutByte_t rdAddr,
  output lutByte_t rdData
);
  lutByte_t mem [LUT_ENTRIES];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // non-blocking read: a same-cycle write is seen only on the next read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int PIX_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  lutByte_t          pixR,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [PIX_W-1:0]  pixNum,
  input  logic [LINE_W-1:0] firstActive,
  input  logic [PIX_W-1:0]  halfLine,
  input  logic              modeBypass,
  input  logic              modeIndexed,
  input  logic              modeInband,
  input  logic              hostWe,
  input  logic [1:0]        hostSel,
  input  lutByte_t          hostAddr,
  input  lutByte_t          hostData,
  output lutStrobe_t        strobe,
  output logic [CNT_W-1:0]  loadCount
);
  logic [CNT_W-1:0] entryCnt;
  logic [1:0]       laneCnt;
  logic [CNT_W-1:0] curEntry;
  logic [1:0]       curLane;
  logic             onLineA;
  logic             onLineB;
  logic             inWindow;
  logic             winOpen;
  logic             takeByte;
  logic [NUM_LANES-1:0] hostLane;

  assign onLineA  = (lineNum == firstActive - LINE_W'(2));
  assign onLineB  = (lineNum == firstActive - LINE_W'(1));
  assign inWindow = onLineA || (onLineB && (pixNum < halfLine));
  assign winOpen  = pixValid && onLineA && (pixNum == '0);

  assign curEntry = winOpen ? '0 : entryCnt;
  assign curLane  = winOpen ? 2'd0 : laneCnt;
  assign takeByte = modeInband && pixValid && inWindow && !curEntry[CNT_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryCnt <= '0;
      laneCnt  <= 2'd0;
    end else if (takeByte) begin
      if (curLane == 2'd2) begin
        laneCnt  <= 2'd0;
        entryCnt <= curEntry + CNT_W'(1);
      end else begin
        laneCnt  <= curLane + 2'd1;
        entryCnt <= curEntry;
      end
    end else if (winOpen) begin
      laneCnt  <= 2'd0;
      entryCnt <= '0;
    end
  end

  always_comb begin
    case (hostSel)
      2'd0:    hostLane = 3'b001;
      2'd1:    hostLane = 3'b010;
      2'd2:    hostLane = 3'b100;
      default: hostLane = 3'b000;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.useIndex = modeIndexed;
    strobe.bypass   = modeBypass;
    if (takeByte) begin
      strobe.wrEn   = NUM_LANES'(1) << curLane;
      strobe.wrAddr = curEntry[LUT_DW-1:0];
      strobe.wrData = pixR;
    end else if (hostWe) begin
      strobe.wrEn   = hostLane;
      strobe.wrAddr = hostAddr;
      strobe.wrData = hostData;
    end
  end

  assign loadCount = entryCnt;
endmodule

// File: rtl/clut_path.sv
module clut_path
  import clut_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lutStrobe_t strobe,
  input  logic       pixValid,
  input  lutByte_t   pixR,
  input  lutByte_t   pixG,
  input  lutByte_t   pixB,
  output logic       outValid,
  output lutByte_t   outR,
  output lutByte_t   outG,
  output lutByte_t   outB
);
  lutByte_t rawIn  [NUM_LANES];
  lutByte_t rdAddr [NUM_LANES];
  lutByte_t lutQ   [NUM_LANES];
  lutByte_t rawQ   [NUM_LANES];
  lutByte_t laneOut[NUM_LANES];
  logic     bypQ;

  assign rawIn[0] = pixR;
  assign rawIn[1] = pixG;
  assign rawIn[2] = pixB;

  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      assign rdAddr[l] = strobe.useIndex ? pixR : rawIn[l];

      clut_table u_tab (
        .clk    (clk),
        .rstN   (rstN),
        .wrEn   (strobe.wrEn[l]),
        .wrAddr (strobe.wrAddr),
        .wrData (strobe.wrData),
        .rdEn   (pixValid),
        .rdAddr (rdAddr[l]),
        .rdData (lutQ[l])
      );

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         rawQ[l] <= '0;
        else if (pixValid) rawQ[l] <= rawIn[l];
      end

      assign laneOut[l] = bypQ ? rawQ[l] : lutQ[l];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bypQ     <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= pixValid;
      if (pixValid) bypQ <= strobe.bypass;
    end
  end

  assign outR = laneOut[0];
  assign outG = laneOut[1];
  assign outB = laneOut[2];
endmodule

// File: rtl/clut_stage.sv
module clut_stage
  import clut_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int PIX_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic [7:0]        pixR,
  input  logic [7:0]        pixG,
  input  logic [7:0]        pixB,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [PIX_W-1:0]  pixNum,
  input  logic [LINE_W-1:0] firstActive,
  input  logic [PIX_W-1:0]  halfLine,
  input  logic              modeBypass,
  input  logic              modeIndexed,
  input  logic              modeInband,
  input  logic              hostWe,
  input  logic [1:0]        hostSel,
  input  logic [7:0]        hostAddr,
  input  logic [7:0]        hostData,
  output logic              outValid,
  output logic [7:0]        outR,
  output logic [7:0]        outG,
  output logic [7:0]        outB
);
  lutStrobe_t       strobe;
  logic [CNT_W-1:0] loadCount;

  clut_ctrl #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pixValid    (pixValid),
    .pixR        (pixR),
    .lineNum     (lineNum),
    .pixNum      (pixNum),
    .firstActive (firstActive),
    .halfLine    (halfLine),
    .modeBypass  (modeBypass),
    .modeIndexed (modeIndexed),
    .modeInband  (modeInband),
    .hostWe      (hostWe),
    .hostSel     (hostSel),
    .hostAddr    (hostAddr),
    .hostData    (hostData),
    .strobe      (strobe),
    .loadCount   (loadCount)
  );

  clut_path u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pixValid (pixValid),
    .pixR     (pixR),
    .pixG     (pixG),
    .pixB     (pixB),
    .outValid (outValid),
    .outR     (outR),
    .outG     (outG),
    .outB     (outB)
  );
endmodule

// File: rtl/clut_checker.sv
module clut_checker
  import clut_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 pixValid,
  input logic [7:0]           pixR,
  input logic [7:0]           pixG,
  input logic [7:0]           pixB,
  input logic                 modeBypass,
  input logic                 outValid,
  input logic [7:0]           outR,
  input logic [7:0]           outG,
  input logic [7:0]           outB,
  input logic [NUM_LANES-1:0] wrEn,
  input logic [CNT_W-1:0]     loadCount
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) pixValid |=> outValid); // R2
  AST_VALID_DROPS:   assert property (@(posedge clk) disable iff (!rstN) !pixValid |=> !outValid); // R2
  AST_BYPASS_EQUAL:  assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && modeBypass) |=> (outR == $past(pixR) && outG == $past(pixG) && outB == $past(pixB))); // R4
  AST_HOLD_IDLE:     assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> ($stable(outR) && $stable(outG) && $stable(outB))); // R10
  AST_ONE_TABLE:     assert property (@(posedge clk) disable iff (!rstN) $onehot0(wrEn)); // R5
  AST_LOAD_CAP:      assert property (@(posedge clk) disable iff (!rstN) loadCount <= CNT_W'(LUT_ENTRIES)); // R8
endmodule

bind clut_stage clut_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .pixValid   (pixValid),
  .pixR       (pixR),
  .pixG       (pixG),
  .pixB       (pixB),
  .modeBypass (modeBypass),
  .outValid   (outValid),
  .outR       (outR),
  .outG       (outG),
  .outB       (outB),
  .wrEn       (strobe.wrEn),
  .loadCount  (loadCount)
);

// File: tb/clut_stage_bench.sv
module clut_stage_bench;
  localparam int LW = 6;
  localparam int PW = 10;
  localparam int LINE_PIX = 512;
  localparam int FIRST = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixValid = 1'b0;
  logic [7:0] pixR = '0, pixG = '0, pixB = '0;
  logic [LW-1:0] lineNum = '0;
  logic [PW-1:0] pixNum = '0;
  logic [LW-1:0] firstActive = LW'(FIRST);
  logic [PW-1:0] halfLine = PW'(400);
  logic modeBypass = 1'b0, modeIndexed = 1'b0, modeInband = 1'b0;
  logic hostWe = 1'b0;
  logic [1:0] hostSel = '0;
  logic [7:0] hostAddr = '0, hostData = '0;
  logic outValid;
  logic [7:0] outR, outG, outB;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] expT [3][256];

  always #10 clk = ~clk;

  clut_stage #(.LINE_W(LW), .PIX_W(PW)) u_clut_stage (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixR(pixR), .pixG(pixG), .pixB(pixB),
    .lineNum(lineNum), .pixNum(pixNum), .firstActive(firstActive), .halfLine(halfLine),
    .modeBypass(modeBypass), .modeIndexed(modeIndexed), .modeInband(modeInband),
    .hostWe(hostWe), .hostSel(hostSel), .hostAddr(hostAddr), .hostData(hostData),
    .outValid(outValid), .outR(outR), .outG(outG), .outB(outB)
  );

  function automatic logic [7:0] fnR(int i); return 8'(i) ^ 8'h5A; endfunction
  function automatic logic [7:0] fnG(int i); return 8'(i * 5 + 1); endfunction
  function automatic logic [7:0] fnB(int i); return ~8'(i); endfunction
  function automatic logic [7:0] fnLoad(int k, int seed); return 8'(k * 7 + seed); endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(logic [1:0] sel, logic [7:0] addr, logic [7:0] data);
    pixValid = 1'b0; hostWe = 1'b1; hostSel = sel; hostAddr = addr; hostData = data;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic pixStep(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    pixValid = 1'b1; pixR = r; pixG = g; pixB = b;
    @(negedge clk);
  endtask

  task automatic checkRgb(string tag, logic [7:0] r, logic [7:0] g, logic [7:0] b);
    check8({tag, " valid"}, {7'd0, outValid}, 8'd1);
    check8({tag, " red"}, outR, r);
    check8({tag, " green"}, outG, g);
    check8({tag, " blue"}, outB, b);
  endtask

  // R6 R7 R8: drive lines FIRST-2 and FIRST-1 with load bytes
  task automatic loadFrame(int seed, int half);
    int k = 0;
    halfLine = PW'(half);
    modeInband = 1'b1;
    for (int ln = FIRST - 2; ln <= FIRST; ln++) begin
      for (int p = 0; p < LINE_PIX; p++) begin
        logic [7:0] v;
        if (ln == FIRST - 2 || (ln == FIRST - 1 && p < half)) begin
          if (k < 768) begin
            v = fnLoad(k, seed);
            expT[k % 3][k / 3] = v;
          end else begin
            v = 8'hEE;
          end
          k++;
        end else begin
          v = 8'hC3;
        end
        lineNum = LW'(ln); pixNum = PW'(p);
        if (ln == FIRST && p >= 32) break;
        pixStep(v, 8'h00, 8'h00);
      end
    end
    pixValid = 1'b0; modeInband = 1'b0; lineNum = LW'(20); pixNum = '0;
    @(negedge clk);
  endtask

  task automatic sweepTables(string tag);
    for (int e = 0; e < 256; e++) begin
      pixStep(8'(e), 8'(e), 8'(e));
      checkRgb(tag, expT[0][e], expT[1][e], expT[2][e]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    lineNum = LW'(20);
    repeat (3) @(negedge clk);
    // R1: reset state
    check8("R1 valid", {7'd0, outValid}, 8'd0);
    check8("R1 red", outR, 8'd0);
    check8("R1 green", outG, 8'd0);
    check8("R1 blue", outB, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    check8("R1 valid after release", {7'd0, outValid}, 8'd0);
    check8("R1 red after release", outR, 8'd0);

    // R5: host fills every entry of all three tables
    for (int e = 0; e < 256; e++) begin
      hostWrite(2'd0, 8'(e), fnR(e)); expT[0][e] = fnR(e);
      hostWrite(2'd1, 8'(e), fnG(e)); expT[1][e] = fnG(e);
      hostWrite(2'd2, 8'(e), fnB(e)); expT[2][e] = fnB(e);
    end
    hostWrite(2'd3, 8'd0, 8'hFF);

    // R2: per-component mapping with distinct lane values
    for (int i = 0; i < 256; i++) begin
      pixStep(8'(i), 8'(i + 1), 8'(i * 3));
      checkRgb("R2 R5 map", expT[0][i], expT[1][8'(i + 1)], expT[2][8'(i * 3)]);
    end
    pixValid = 1'b0;
    @(negedge clk);
    check8("R2 valid low", {7'd0, outValid}, 8'd0);

    // R3: indexed mode, green/blue lanes carry noise
    modeIndexed = 1'b1;
    for (int i = 0; i < 256; i++) begin
      pixStep(8'(i), ~8'(i), 8'h55);
      checkRgb("R3 indexed", expT[0][i], expT[1][i], expT[2][i]);
    end
    modeIndexed = 1'b0;

    // R4: bypass toggled every pixel
    for (int i = 0; i < 256; i++) begin
      modeBypass = i[0];
      pixStep(8'(i), 8'(i + 7), 8'(255 - i));
      if (i[0]) checkRgb("R4 bypass", 8'(i), 8'(i + 7), 8'(255 - i));
      else      checkRgb("R4 mapped", expT[0][i], expT[1][8'(i + 7)], expT[2][8'(255 - i)]);
    end
    modeBypass = 1'b0;

    // R10: outputs hold while idle
    pixStep(8'd7, 8'd8, 8'd9);
    pixValid = 1'b0; pixR = 8'd99; pixG = 8'd98; pixB = 8'd97;
    @(negedge clk);
    @(negedge clk);
    check8("R10 valid", {7'd0, outValid}, 8'd0);
    check8("R10 red hold", outR, expT[0][7]);
    check8("R10 green hold", outG, expT[1][8]);
    check8("R10 blue hold", outB, expT[2][9]);

    // R9: same-cycle write and read of entry 5
    begin
      logic [7:0] oldV;
      oldV = expT[0][5];
      hostWe = 1'b1; hostSel = 2'd0; hostAddr = 8'd5; hostData = ~oldV;
      pixValid = 1'b1; pixR = 8'd5; pixG = 8'd0; pixB = 8'd0;
      @(negedge clk);
      hostWe = 1'b0;
      check8("R9 old value on collision", outR, oldV);
      expT[0][5] = ~oldV;
      pixStep(8'd5, 8'd0, 8'd0);
      check8("R9 new value next read", outR, ~oldV);
    end
    pixValid = 1'b0;
    @(negedge clk);

    // R6 R7 R8: full in-band load, extra bytes after 768 ignored
    loadFrame(3, 400);
    sweepTables("R6 R8 full load");
    // R7 R8: second frame, counter restarts, window closes early
    loadFrame(101, 100);
    sweepTables("R7 R8 short window");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule